// File: doc/BRIEF.md
# Low-Power Mode and Brown-out Controller

This controller sequences the sleep states of a small microcontroller core and its recovery from supply loss. Software raises a one-cycle request to enter either a light sleep, where only the CPU clock stops and peripherals keep running, or a deep sleep, where the oscillator is switched off. Light sleep ends when any pending enabled interrupt is seen. Deep sleep ignores interrupts and ends only on the external reset pin. On that exit the oscillator is re-enabled first, and internal reset is held through a stabilisation window.

A digital supply-monitor flag overrides every other condition. While it is raised, the controller gates the core, drops any pending sleep request and weakly pulls all port pins high except the reserved ones. When the flag clears, the controller counts a recovery delay and then issues an internal reset by itself. Only a cold reset on the asynchronous system reset asks for RAM to be initialised. Warm resets leave RAM contents alone.

Top module: `lpm_bod_ctrl`

## Requirements
- R1: While `rst_n` is low, `int_rst`, `ram_init`, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 1. In the first cycle after release, `int_rst` and `ram_init` go to 0 and the core runs.
- R2: A pulse on `idle_req` while running makes `cpu_clk_en` 0 in the next cycle, while `per_clk_en` and `osc_en` stay 1.
- R3: In light sleep, any set bit of `irq_pend` makes `cpu_clk_en` 1 in the next cycle. With `irq_pend` all zero the core stays asleep. `ext_rst` also ends light sleep, with `int_rst` set in the next cycle.
- R4: A pulse on `pd_req` while running makes `cpu_clk_en`, `per_clk_en` and `osc_en` 0 in the next cycle.
- R5: In deep sleep, `irq_pend`, `idle_req` and `pd_req` have no effect, and `osc_en` stays 0. Requests that arrive in any state other than running are discarded.
- R6: When `ext_rst` is raised in deep sleep, `osc_en` becomes 1 in the next cycle. `int_rst` then stays 1 for exactly OSC_STAB_CYC cycles, plus one further cycle once `ext_rst` is low. `ram_init` stays 0 throughout.
- R7: If `idle_req` and `pd_req` arrive in the same cycle, deep sleep is entered.
- R8: In the cycle after `bod_flag` is seen high, from any state, `port_pullup` is 1 on every bit except the reserved bits set in RSV_MASK (default bits 0 and 1, giving 8'hFC for 8 ports). In that cycle `int_rst` and `cpu_clk_en` are 0, and any earlier sleep request is discarded.
- R9: After `bod_flag` falls, `port_pullup` returns to 0. `int_rst` rises exactly RECOV_CYC+1 cycles later and lasts one cycle, with `ram_init` at 0. The core then runs, not sleeps.
- R10: While running, `int_rst` follows `ext_rst` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| ext_rst | input | 1 | External hardware reset pin, synchronous, active high |
| bod_flag | input | 1 | Supply-monitor flag, high while the supply is low |
| idle_req | input | 1 | One-cycle request for light sleep |
| pd_req | input | 1 | One-cycle request for deep sleep |
| irq_pend | input | IRQ_W | Pending enabled interrupt lines |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| port_pullup | output | PORT_W | Weak pull-high override per port pin |
| int_rst | output | 1 | Internal reset to core and registers |
| ram_init | output | 1 | RAM initialise request, cold reset only |

## Verification
Every output is decoded from the registered mode, so a wrong mode shows up on the clock and reset enables one cycle after the input that caused it. For example, an interrupt wrongly waking deep sleep raises `osc_en` at once. A miscounted delay counter changes how long `int_rst` stays high after a deep-sleep wake, or when it rises after the supply recovers, by exactly the error. The bench therefore counts those windows cycle by cycle. A request that is not cleared on a supply dip shows up after the recovery reset as a gated `cpu_clk_en`.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    ST_COLD  = 3'd0,
    ST_RUN   = 3'd1,
    ST_IDLE  = 3'd2,
    ST_PDOWN = 3'd3,
    ST_STAB  = 3'd4,
    ST_RESET = 3'd5,
    ST_BOD   = 3'd6,
    ST_RECOV = 3'd7
  } lpm_state_e;
endpackage

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  lpm_state_e state_q,
  input  logic       idle_req,
  input  logic       pd_req,
  input  logic       wake_irq,
  input  logic       ext_rst,
  input  logic       bod_flag,
  input  logic       tmr_done,
  output lpm_state_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLD:  state_d = ST_RUN;
      ST_RUN: begin
        if (ext_rst)       state_d = ST_RESET;
        else if (pd_req)   state_d = ST_PDOWN;
        else if (idle_req) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (ext_rst)       state_d = ST_RESET;
        else if (wake_irq) state_d = ST_RUN;
      end
      ST_PDOWN: if (ext_rst) state_d = ST_STAB;
      ST_STAB:  if (tmr_done) state_d = ST_RESET;
      ST_RESET: if (!ext_rst) state_d = ST_RUN;
      ST_BOD:   state_d = ST_RECOV;
      ST_RECOV: if (ext_rst || tmr_done) state_d = ST_RESET;
      default:  state_d = ST_COLD;
    endcase
    // supply loss overrides every mode and drops pending requests
    if (bod_flag) state_d = ST_BOD;
  end
endmodule

// File: rtl/lpm_timer.sv
module lpm_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = en && (cnt_q == (limit - ONE));
endmodule

// File: rtl/lpm_outdec.sv
module lpm_outdec
  import lpm_pkg::*;
#(
  parameter int unsigned       PORT_W   = 8,
  parameter logic [PORT_W-1:0] RSV_MASK = PORT_W'(3)
) (
  input  lpm_state_e        state_q,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              int_rst,
  output logic              ram_init,
  output logic [PORT_W-1:0] port_pullup
);
  logic in_bod;

  assign in_bod     = (state_q == ST_BOD);
  assign cpu_clk_en = (state_q == ST_RUN) || (state_q == ST_RESET) || (state_q == ST_COLD);
  assign per_clk_en = cpu_clk_en || (state_q == ST_IDLE);
  assign osc_en     = (state_q != ST_PDOWN);
  assign int_rst    = (state_q == ST_COLD) || (state_q == ST_RESET) || (state_q == ST_STAB);
  assign ram_init   = (state_q == ST_COLD);

  for (genvar g = 0; g < int'(PORT_W); g++) begin : g_pull
    if (RSV_MASK[g]) begin : g_rsv
      assign port_pullup[g] = 1'b0;
    end else begin : g_ovr
      assign port_pullup[g] = in_bod;
    end
  end
endmodule

// File: rtl/lpm_bod_ctrl.sv
module lpm_bod_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned       PORT_W       = 8,
  parameter logic [PORT_W-1:0] RSV_MASK     = PORT_W'(3),
  parameter int unsigned       IRQ_W        = 4,
  parameter int unsigned       OSC_STAB_CYC = 1024,
  parameter int unsigned       RECOV_CYC    = 1500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              bod_flag,
  input  logic              idle_req,
  input  logic              pd_req,
  input  logic [IRQ_W-1:0]  irq_pend,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic [PORT_W-1:0] port_pullup,
  output logic              int_rst,
  output logic              ram_init
);
  localparam int unsigned MAX_CYC = (OSC_STAB_CYC > RECOV_CYC) ? OSC_STAB_CYC : RECOV_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  lpm_state_e       state_q, state_d;
  logic             tmr_en, tmr_clr, tmr_done;
  logic [CNT_W-1:0] tmr_limit;

  assign tmr_en    = (state_q == ST_STAB) || (state_q == ST_RECOV);
  assign tmr_clr   = (state_d != state_q);
  assign tmr_limit = (state_q == ST_STAB) ? CNT_W'(OSC_STAB_CYC) : CNT_W'(RECOV_CYC);

  lpm_fsm u_fsm (
    .state_q  (state_q),
    .idle_req (idle_req),
    .pd_req   (pd_req),
    .wake_irq (|irq_pend),
    .ext_rst  (ext_rst),
    .bod_flag (bod_flag),
    .tmr_done (tmr_done),
    .state_d  (state_d)
  );

  lpm_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .en    (tmr_en),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_COLD;
    else        state_q <= state_d;
  end

  lpm_outdec #(.PORT_W(PORT_W), .RSV_MASK(RSV_MASK)) u_dec (
    .state_q     (state_q),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en),
    .int_rst     (int_rst),
    .ram_init    (ram_init),
    .port_pullup (port_pullup)
  );
endmodule

// File: rtl/lpm_bod_ctrl_chk.sv
module lpm_bod_ctrl_chk #(
  parameter int unsigned       PORT_W       = 8,
  parameter logic [PORT_W-1:0] RSV_MASK     = PORT_W'(3),
  parameter int unsigned       IRQ_W        = 4,
  parameter int unsigned       OSC_STAB_CYC = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_rst,
  input logic              bod_flag,
  input logic              pd_req,
  input logic [IRQ_W-1:0]  irq_pend,
  input logic              cpu_clk_en,
  input logic              per_clk_en,
  input logic              osc_en,
  input logic [PORT_W-1:0] port_pullup,
  input logic              int_rst,
  input logic              ram_init
);
  // cycles the oscillator has been enabled, saturating; a cold start counts as settled
  logic [15:0] osc_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                osc_run_q <= '1;
    else if (!osc_en)          osc_run_q <= '0;
    else if (osc_run_q != '1)  osc_run_q <= osc_run_q + 16'd1;
  end

  // R4
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !int_rst && pd_req && !bod_flag && !ext_rst) |=> (!cpu_clk_en && !osc_en));

  // R5
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !ext_rst && !bod_flag) |=> !osc_en);

  // R3
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && per_clk_en && (|irq_pend) && !ext_rst && !bod_flag) |=> cpu_clk_en);

  // R8
  bod_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bod_flag |=> (port_pullup == ~RSV_MASK) && !int_rst);

  // R6
  stab_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst) |-> (osc_run_q >= 16'(OSC_STAB_CYC)));

  // R6
  warm_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !ram_init);

  // R10
  ext_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rst && !bod_flag && (port_pullup == '0)) |=> int_rst);
endmodule

bind lpm_bod_ctrl lpm_bod_ctrl_chk #(
  .PORT_W(PORT_W), .RSV_MASK(RSV_MASK), .IRQ_W(IRQ_W), .OSC_STAB_CYC(OSC_STAB_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .bod_flag(bod_flag), .pd_req(pd_req),
  .irq_pend(irq_pend), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
  .port_pullup(port_pullup), .int_rst(int_rst), .ram_init(ram_init)
);

// File: tb/tb_lpm_bod_ctrl.sv
module tb_lpm_bod_ctrl;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned IRQ_W  = 3;
  localparam int unsigned OSC    = 5;
  localparam int unsigned RECOV  = 20;

  logic clk, rst_n, ext_rst, bod_flag, idle_req, pd_req;
  logic [IRQ_W-1:0]  irq_pend;
  logic cpu_clk_en, per_clk_en, osc_en, int_rst, ram_init;
  logic [PORT_W-1:0] port_pullup;

  int n_run, n_fail;

  lpm_bod_ctrl #(
    .PORT_W(PORT_W), .RSV_MASK(8'h03), .IRQ_W(IRQ_W),
    .OSC_STAB_CYC(OSC), .RECOV_CYC(RECOV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .bod_flag(bod_flag),
    .idle_req(idle_req), .pd_req(pd_req), .irq_pend(irq_pend),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .port_pullup(port_pullup), .int_rst(int_rst), .ram_init(ram_init)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic t_cold();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 int_rst in reset", 32'(int_rst), 1);
    chk("R1 ram_init in reset", 32'(ram_init), 1);
    chk("R1 clocks in reset", {29'd0, cpu_clk_en, per_clk_en, osc_en}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 int_rst after release", 32'(int_rst), 0);
    chk("R1 ram_init after release", 32'(ram_init), 0);
    chk("R1 running", 32'(cpu_clk_en), 1);
  endtask

  task automatic t_idle();
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    chk("R2 idle clocks cpu/per/osc", {29'd0, cpu_clk_en, per_clk_en, osc_en}, 3);
    repeat (3) @(negedge clk);
    chk("R3 no wake without irq", 32'(cpu_clk_en), 0);
    irq_pend = 3'b100;
    @(negedge clk);
    irq_pend = '0;
    chk("R3 irq wakes idle", 32'(cpu_clk_en), 1);
    // reset pin ends idle as well
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    ext_rst = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0;
    chk("R3 ext_rst ends idle", 32'(int_rst), 1);
    @(negedge clk);
    chk("R3 running after reset", {30'd0, cpu_clk_en, int_rst}, 2);
  endtask

  task automatic t_pd();
    int hi;
    logic osc_ok, ram_seen;
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    chk("R4 pd clocks off", {29'd0, cpu_clk_en, per_clk_en, osc_en}, 0);
    irq_pend = 3'b111;
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    pd_req   = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    @(negedge clk);
    irq_pend = '0;
    chk("R5 pd ignores irq/req osc", 32'(osc_en), 0);
    chk("R5 pd ignores irq/req cpu", 32'(cpu_clk_en), 0);
    ext_rst = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0;
    chk("R6 osc on at wake", 32'(osc_en), 1);
    hi = 0; osc_ok = 1'b1; ram_seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (!int_rst) break;
      hi++;
      if (!osc_en) osc_ok = 1'b0;
      if (ram_init) ram_seen = 1'b1;
      @(negedge clk);
    end
    chk("R6 reset window length", 32'(hi), OSC + 1);
    chk("R6 osc held during window", 32'(osc_ok), 1);
    chk("R6 no ram_init on warm reset", 32'(ram_seen), 0);
    chk("R6 running after window", 32'(cpu_clk_en), 1);
  endtask

  task automatic t_both();
    idle_req = 1'b1;
    pd_req   = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    pd_req   = 1'b0;
    chk("R7 both -> pd per", 32'(per_clk_en), 0);
    chk("R7 both -> pd osc", 32'(osc_en), 0);
    ext_rst = 1'b1;
    @(negedge clk);
    ext_rst = 1'b0;
    repeat (OSC + 3) @(negedge clk);
    chk("R7 recovered", 32'(cpu_clk_en), 1);
  endtask

  task automatic t_bod();
    int first;
    logic pull_clear;
    idle_req = 1'b1;
    @(negedge clk);
    idle_req = 1'b0;
    bod_flag = 1'b1;
    @(negedge clk);
    chk("R8 pullup mask", 32'(port_pullup), 32'h0000_00FC);
    chk("R8 no int_rst during bod", 32'(int_rst), 0);
    chk("R8 cpu gated", 32'(cpu_clk_en), 0);
    repeat (3) @(negedge clk);
    bod_flag = 1'b0;
    @(negedge clk);
    first = 0; pull_clear = 1'b1;
    for (int i = 1; i <= 60; i++) begin
      if (int_rst) begin first = i; break; end
      if (port_pullup != '0) pull_clear = 1'b0;
      @(negedge clk);
    end
    chk("R9 recovery delay", 32'(first), RECOV + 1);
    chk("R9 pullup released", 32'(pull_clear), 1);
    chk("R9 no ram_init", 32'(ram_init), 0);
    @(negedge clk);
    chk("R9 reset one cycle", 32'(int_rst), 0);
    chk("R8 request dropped, core runs", 32'(cpu_clk_en), 1);
    // supply dip during deep sleep
    pd_req = 1'b1;
    @(negedge clk);
    pd_req   = 1'b0;
    bod_flag = 1'b1;
    @(negedge clk);
    bod_flag = 1'b0;
    chk("R8 bod from pd", 32'(port_pullup), 32'h0000_00FC);
    repeat (RECOV + 3) @(negedge clk);
    chk("R9 runs after pd dip", 32'(cpu_clk_en), 1);
  endtask

  task automatic t_ext();
    ext_rst = 1'b1;
    @(negedge clk);
    chk("R10 int_rst follows pin c1", 32'(int_rst), 1);
    @(negedge clk);
    chk("R10 int_rst follows pin c2", 32'(int_rst), 1);
    @(negedge clk);
    ext_rst = 1'b0;
    chk("R10 int_rst follows pin c3", 32'(int_rst), 1);
    @(negedge clk);
    chk("R10 int_rst drops", 32'(int_rst), 0);
    chk("R10 ram_init stays low", 32'(ram_init), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0;
    ext_rst = 1'b0; bod_flag = 1'b0; idle_req = 1'b0; pd_req = 1'b0; irq_pend = '0;
    rst_n = 1'b0;
    @(negedge clk);
    t_cold();
    t_idle();
    t_pd();
    t_both();
    t_bod();
    t_ext();
    finish_run();
  end
endmodule